// File: doc/BRIEF.md
# Banked Register Operand Collector

This block sits between instruction decode and execute in a SIMT pipeline. It owns a fixed pool of collector units. A decoded warp instruction is taken into a free unit, and every valid source register of that instruction becomes a read request. The request goes into a queue attached to one bank of a multi-bank register file. Each cycle, every bank serves at most one access. A writeback that targets a bank takes that bank for the cycle, so a read waiting there is held back.

When every source read of a unit has been granted, the unit is complete. It hands its instruction to the execute pipeline register, but only while that register is empty. Among complete units, the one handed over is chosen round-robin. Free units sit on a stack, and the unit freed most recently is the next one reused. A unit that dispatches in a cycle can take a new instruction in that same cycle.

The register file data path and the execute units are outside the block. It drives per-bank read enables and read register numbers, and reports which unit dispatched, with that unit's tag and thread id.

Top module: `oc_collector`

## Requirements
- R1: After reset, all units are free, `in_ready` is 1, `ex_load` is 0 and `rf_rd_en` is all zero.
- R2: The bank of a register is (register number + thread id) modulo NUM_BANKS. This holds for source reads and for writebacks alike.
- R3: An instruction is accepted only when a unit is free. `in_ready` is 0 when every unit is occupied and none dispatches that cycle. Free units are reused last-freed-first, and after reset they are handed out from unit NUM_UNITS-1 downward.
- R4: On acceptance, each valid source (operand slot 0 to 3, with slot 0 enqueued first) is appended to its bank's queue. A bank grants its oldest request, at most one per cycle, starting the cycle after acceptance. A grant shows as `rf_rd_en[b]`=1, with the register on `rf_rd_reg[b*REG_W +: REG_W]`.
- R5: While `wb_valid` is 1, the bank of (`wb_reg` + `wb_tid`) grants no read. Its pending request stays at the head of the queue, and other banks are not affected.
- R6: A unit becomes complete in the cycle after its last read grant. A unit with no valid sources becomes complete in the cycle after acceptance. A unit never dispatches before that.
- R7: `ex_load` is 1 only while `ex_empty` is 1, and at most one unit dispatches per cycle. `ex_unit`, `ex_tag` and `ex_tid` carry the dispatching unit and the tag and thread id it was loaded with.
- R8: The dispatch search starts at the unit after the last one that dispatched and wraps around. After reset, the search starts at unit 0.
- R9: A unit that dispatches in a cycle can accept a new instruction in that same cycle. In that case `in_ready` is 1 even though every unit is occupied.
- R10: Each bank queue holds NUM_UNITS*4 entries. No mix of accepted instructions can overflow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | A collector unit can take the instruction |
| in_tid | input | TID_W | Thread id of the first active thread |
| in_tag | input | TAG_W | Opaque instruction tag carried to execute |
| in_src_vld | input | 4 | Per operand slot: source register present |
| in_src_reg | input | 4*REG_W | Source register numbers, slot s at s*REG_W |
| wb_valid | input | 1 | Writeback claims a bank this cycle |
| wb_tid | input | TID_W | Thread id of the writeback |
| wb_reg | input | REG_W | Destination register of the writeback |
| rf_rd_en | output | NUM_BANKS | Per-bank read grant |
| rf_rd_reg | output | NUM_BANKS*REG_W | Per-bank register being read |
| ex_empty | input | 1 | Execute pipeline register is empty |
| ex_load | output | 1 | A unit dispatches this cycle |
| ex_unit | output | UNIT_W | Index of the dispatching unit |
| ex_tid | output | TID_W | Thread id of the dispatched instruction |
| ex_tag | output | TAG_W | Tag of the dispatched instruction |

## Verification
The assertions assume a single writeback per cycle and treat `ex_empty` as a free input. They place no constraint on how `in_valid` relates to `in_ready`. They do assume that an offered instruction is held, or withdrawn, at the driver's choice.

The stimulus keeps to the default configuration of four units and four banks. It sweeps every register/thread pair in a window to cover the bank mapping. Writebacks are held on a bank to pile up requests: one run fills every unit with four reads on a single bank, which reaches the full queue depth. Dispatch is blocked through `ex_empty` to fill all units and observe allocation and round-robin order.

// File: rtl/oc_pkg.sv
package oc_pkg;

   // Source operand slots per instruction.
   localparam int unsigned OC_NUM_SRC = 4;

   // What a register bank is doing in the current cycle.
   typedef enum logic [1:0] {
      BANK_IDLE  = 2'd0,
      BANK_READ  = 2'd1,
      BANK_WRITE = 2'd2
   } bank_use_e;

endpackage

// File: rtl/oc_bank_map.sv
module oc_bank_map #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned REG_W     = 6,
   parameter int unsigned TID_W     = 5,
   parameter int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [TID_W-1:0]  tid,
   output logic [BANK_W-1:0] bank
);

   localparam int unsigned SUM_W = ((REG_W > TID_W) ? REG_W : TID_W) + 1;

   // Power-of-two bank count: plain truncation. Otherwise: a true modulo.
   if ((NUM_BANKS & (NUM_BANKS - 1)) == 0) begin : g_pow2
      assign bank = BANK_W'(reg_idx) + BANK_W'(tid);
   end else begin : g_mod
      logic [SUM_W-1:0] sum;
      assign sum  = SUM_W'(reg_idx) + SUM_W'(tid);
      assign bank = BANK_W'(32'(sum) % NUM_BANKS);
   end

endmodule

// File: rtl/oc_bank_queue.sv
module oc_bank_queue #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned ENT_W    = 10,
   parameter int unsigned NUM_PUSH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PUSH-1:0]       push_en,
   input  logic [NUM_PUSH*ENT_W-1:0] push_data,
   input  logic                      pop,
   output logic                      head_valid,
   output logic [ENT_W-1:0]          head_data
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("oc_bank_queue: DEPTH must be at least 2");
   end

   logic [ENT_W-1:0] mem_q [DEPTH];
   logic [ENT_W-1:0] mem_n [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_n;

   assign head_valid = (cnt_q != '0);
   assign head_data  = mem_q[0];

   // Shift-down queue: pop first, then append pushes in slot order.
   always_comb begin
      for (int i = 0; i < DEPTH; i++) mem_n[i] = mem_q[i];
      cnt_n = cnt_q;
      if (pop && head_valid) begin
         for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
         cnt_n = cnt_n - 1'b1;
      end
      for (int p = 0; p < NUM_PUSH; p++) begin
         if (push_en[p]) begin
            if (cnt_n < CNT_W'(DEPTH)) mem_n[IDX_W'(cnt_n)] = push_data[p*ENT_W +: ENT_W];
            cnt_n = cnt_n + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         cnt_q <= cnt_n;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
      end
   end

   // R10: occupancy after this cycle's pop and pushes stays within capacity.
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cnt_q) + 32'($countones(push_en)) - 32'(pop && head_valid)) <= DEPTH);

   // R4: a grant is only ever taken from a non-empty queue.
   p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_valid);

endmodule

// File: rtl/oc_rr_pick.sv
module oc_rr_pick #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] last,
   output logic             found,
   output logic [IDX_W-1:0] pick
);

   logic [IDX_W-1:0] idx;

   // Walk from farthest to nearest so the nearest after 'last' wins.
   always_comb begin
      found = 1'b0;
      pick  = '0;
      idx   = '0;
      for (int k = N; k >= 1; k--) begin
         idx = IDX_W'((int'(last) + k) % N);
         if (req[idx]) begin
            found = 1'b1;
            pick  = idx;
         end
      end
   end

endmodule

// File: rtl/oc_collector.sv
module oc_collector #(
   parameter int unsigned NUM_UNITS = 4,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned REG_W     = 6,
   parameter int unsigned TID_W     = 5,
   parameter int unsigned TAG_W     = 8,
   parameter int unsigned UNIT_W    = $clog2(NUM_UNITS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [TID_W-1:0]               in_tid,
   input  logic [TAG_W-1:0]               in_tag,
   input  logic [oc_pkg::OC_NUM_SRC-1:0]  in_src_vld,
   input  logic [oc_pkg::OC_NUM_SRC*REG_W-1:0] in_src_reg,
   input  logic                           wb_valid,
   input  logic [TID_W-1:0]               wb_tid,
   input  logic [REG_W-1:0]               wb_reg,
   output logic [NUM_BANKS-1:0]           rf_rd_en,
   output logic [NUM_BANKS*REG_W-1:0]     rf_rd_reg,
   input  logic                           ex_empty,
   output logic                           ex_load,
   output logic [UNIT_W-1:0]              ex_unit,
   output logic [TID_W-1:0]               ex_tid,
   output logic [TAG_W-1:0]               ex_tag
);

   import oc_pkg::*;

   localparam int unsigned NUM_SRC = OC_NUM_SRC;
   localparam int unsigned BANK_W  = $clog2(NUM_BANKS);
   localparam int unsigned OP_W    = $clog2(NUM_SRC);
   localparam int unsigned QDEPTH  = NUM_UNITS * NUM_SRC;
   localparam int unsigned ENT_W   = UNIT_W + OP_W + REG_W;
   localparam int unsigned STK_W   = $clog2(NUM_UNITS + 1);

   if (NUM_UNITS < 2) begin : g_bad_units
      $error("oc_collector: NUM_UNITS must be at least 2");
   end
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("oc_collector: NUM_BANKS must be at least 2");
   end
   if (UNIT_W != $clog2(NUM_UNITS)) begin : g_bad_unit_w
      $error("oc_collector: UNIT_W must equal clog2(NUM_UNITS)");
   end

   // ---------------- unit state ----------------
   logic [NUM_UNITS-1:0] occ;
   logic [NUM_SRC-1:0]   pend  [NUM_UNITS];
   logic [NUM_SRC-1:0]   clr   [NUM_UNITS];
   logic [TAG_W-1:0]     u_tag [NUM_UNITS];
   logic [TID_W-1:0]     u_tid [NUM_UNITS];
   logic [NUM_UNITS-1:0] complete;

   // ---------------- dispatch ----------------
   logic [UNIT_W-1:0] last_q;
   logic              disp_found;
   logic [UNIT_W-1:0] disp_pick;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_ready
      assign complete[u] = occ[u] & (pend[u] == '0);
   end

   oc_rr_pick #(.N(NUM_UNITS), .IDX_W(UNIT_W)) u_rr (
      .req   (complete),
      .last  (last_q),
      .found (disp_found),
      .pick  (disp_pick)
   );

   assign ex_load = ex_empty & disp_found;
   assign ex_unit = disp_pick;
   assign ex_tag  = u_tag[disp_pick];
   assign ex_tid  = u_tid[disp_pick];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= UNIT_W'(NUM_UNITS - 1);
      else if (ex_load) last_q <= disp_pick;
   end

   // ---------------- free-unit stack ----------------
   logic [UNIT_W-1:0] stk [NUM_UNITS];
   logic [STK_W-1:0]  top_q;
   logic              alloc_fire;
   logic [UNIT_W-1:0] alloc_unit;
   logic [UNIT_W-1:0] pop_idx;

   assign in_ready   = (top_q != '0) | ex_load;
   assign alloc_fire = in_valid & in_ready;
   assign pop_idx    = (top_q == '0) ? '0 : UNIT_W'(top_q - 1'b1);
   // A unit released this cycle sits on top of the stack, so it is reused first.
   assign alloc_unit = ex_load ? disp_pick : stk[pop_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= STK_W'(NUM_UNITS);
         for (int i = 0; i < NUM_UNITS; i++) stk[i] <= UNIT_W'(i);
      end else if (ex_load && !alloc_fire) begin
         stk[UNIT_W'(top_q)] <= disp_pick;
         top_q <= top_q + 1'b1;
      end else if (alloc_fire && !ex_load) begin
         top_q <= top_q - 1'b1;
      end
   end

   // ---------------- bank mapping ----------------
   logic [REG_W-1:0]  src_reg  [NUM_SRC];
   logic [BANK_W-1:0] src_bank [NUM_SRC];
   logic [BANK_W-1:0] wb_bank;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign src_reg[s] = in_src_reg[s*REG_W +: REG_W];
      oc_bank_map #(.NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .TID_W(TID_W), .BANK_W(BANK_W)) u_map (
         .reg_idx (src_reg[s]),
         .tid     (in_tid),
         .bank    (src_bank[s])
      );
   end

   oc_bank_map #(.NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .TID_W(TID_W), .BANK_W(BANK_W)) u_wb_map (
      .reg_idx (wb_reg),
      .tid     (wb_tid),
      .bank    (wb_bank)
   );

   // ---------------- per-bank queues and grants ----------------
   logic [NUM_BANKS-1:0] rd_gnt;
   logic [NUM_BANKS-1:0] head_vld;
   logic [ENT_W-1:0]     head_ent  [NUM_BANKS];
   logic [UNIT_W-1:0]    head_unit [NUM_BANKS];
   logic [OP_W-1:0]      head_op   [NUM_BANKS];
   logic [REG_W-1:0]     head_reg  [NUM_BANKS];
   bank_use_e            bank_use  [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [NUM_SRC-1:0]       push_en;
      logic [NUM_SRC*ENT_W-1:0] push_data;
      logic                     wb_hit;

      always_comb begin
         for (int s = 0; s < NUM_SRC; s++) begin
            push_en[s] = alloc_fire & in_src_vld[s] & (src_bank[s] == BANK_W'(b));
            push_data[s*ENT_W +: ENT_W] = {alloc_unit, OP_W'(s), src_reg[s]};
         end
      end

      oc_bank_queue #(.DEPTH(QDEPTH), .ENT_W(ENT_W), .NUM_PUSH(NUM_SRC)) u_q (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_en    (push_en),
         .push_data  (push_data),
         .pop        (rd_gnt[b]),
         .head_valid (head_vld[b]),
         .head_data  (head_ent[b])
      );

      assign head_unit[b] = head_ent[b][ENT_W-1 -: UNIT_W];
      assign head_op[b]   = head_ent[b][REG_W +: OP_W];
      assign head_reg[b]  = head_ent[b][REG_W-1:0];

      // The writeback reservation is made before reads are considered.
      assign wb_hit      = wb_valid & (wb_bank == BANK_W'(b));
      assign bank_use[b] = wb_hit      ? BANK_WRITE :
                           head_vld[b] ? BANK_READ  : BANK_IDLE;
      assign rd_gnt[b]   = (bank_use[b] == BANK_READ);

      assign rf_rd_en[b]                  = rd_gnt[b];
      assign rf_rd_reg[b*REG_W +: REG_W]  = rd_gnt[b] ? head_reg[b] : '0;

      // R5: a bank taken by writeback grants no read in that cycle.
      p_wb_blocks_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wb_valid && wb_bank == BANK_W'(b)) |-> !rf_rd_en[b]);

      // R4: every granted read belongs to a live unit still waiting on that slot.
      p_grant_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rf_rd_en[b] |-> (occ[head_unit[b]] && pend[head_unit[b]][head_op[b]]));
   end

   // Clear the pending bit of every granted (unit, slot) pair.
   always_comb begin
      for (int u = 0; u < NUM_UNITS; u++) begin
         clr[u] = '0;
         for (int s = 0; s < NUM_SRC; s++)
            for (int b = 0; b < NUM_BANKS; b++)
               if (rd_gnt[b] && head_unit[b] == UNIT_W'(u) && head_op[b] == OP_W'(s))
                  clr[u][s] = 1'b1;
      end
   end

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic               occ_q;
      logic [NUM_SRC-1:0] pend_q;
      logic [TAG_W-1:0]   tag_q;
      logic [TID_W-1:0]   tid_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ_q  <= 1'b0;
            pend_q <= '0;
            tag_q  <= '0;
            tid_q  <= '0;
         end else if (alloc_fire && alloc_unit == UNIT_W'(u)) begin
            occ_q  <= 1'b1;
            pend_q <= in_src_vld;
            tag_q  <= in_tag;
            tid_q  <= in_tid;
         end else if (ex_load && disp_pick == UNIT_W'(u)) begin
            occ_q  <= 1'b0;
            pend_q <= '0;
         end else begin
            pend_q <= pend_q & ~clr[u];
         end
      end

      assign occ[u]   = occ_q;
      assign pend[u]  = pend_q;
      assign u_tag[u] = tag_q;
      assign u_tid[u] = tid_q;
   end

   // R7: dispatch only into an empty execute register.
   p_dispatch_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ex_load |-> ex_empty);

   // R6: only an occupied unit with no pending reads dispatches.
   p_dispatch_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ex_load |-> (occ[ex_unit] && pend[ex_unit] == '0));

   // R6: a dispatch without a same-cycle refill frees exactly one unit.
   p_dispatch_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load && !alloc_fire) |=> ($countones(occ) == $past($countones(occ)) - 1));

   // R3: the free stack and the occupancy flags always account for every unit.
   p_free_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(top_q) + 32'($countones(occ))) == NUM_UNITS);

   // R3: with every unit busy and nothing leaving, nothing is accepted.
   p_stall_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((&occ) && !ex_load) |-> !in_ready);

endmodule

// File: tb/oc_collector_tb.sv
module oc_collector_tb;

   localparam int NU    = 4;
   localparam int NB    = 4;
   localparam int REG_W = 6;
   localparam int TID_W = 5;
   localparam int TAG_W = 8;
   localparam int UW    = 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [TID_W-1:0]     in_tid = '0;
   logic [TAG_W-1:0]     in_tag = '0;
   logic [3:0]           in_src_vld = '0;
   logic [4*REG_W-1:0]   in_src_reg = '0;
   logic                 wb_valid = 1'b0;
   logic [TID_W-1:0]     wb_tid = '0;
   logic [REG_W-1:0]     wb_reg = '0;
   logic [NB-1:0]        rf_rd_en;
   logic [NB*REG_W-1:0]  rf_rd_reg;
   logic                 ex_empty = 1'b1;
   logic                 ex_load;
   logic [UW-1:0]        ex_unit;
   logic [TID_W-1:0]     ex_tid;
   logic [TAG_W-1:0]     ex_tag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   oc_collector #(.NUM_UNITS(NU), .NUM_BANKS(NB), .REG_W(REG_W), .TID_W(TID_W), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid), .in_tag(in_tag),
      .in_src_vld(in_src_vld), .in_src_reg(in_src_reg),
      .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_reg(wb_reg),
      .rf_rd_en(rf_rd_en), .rf_rd_reg(rf_rd_reg),
      .ex_empty(ex_empty), .ex_load(ex_load), .ex_unit(ex_unit), .ex_tid(ex_tid), .ex_tag(ex_tag)
   );

   always #10 clk = ~clk;   // 50 MHz

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint rd_reg(input int b);
      return longint'(rf_rd_reg[b*REG_W +: REG_W]);
   endfunction

   task automatic offer(input int tid, input int tag, input logic [3:0] vld,
                        input int r0, input int r1, input int r2, input int r3);
      in_valid   = 1'b1;
      in_tid     = TID_W'(tid);
      in_tag     = TAG_W'(tag);
      in_src_vld = vld;
      in_src_reg = {REG_W'(r3), REG_W'(r2), REG_W'(r1), REG_W'(r0)};
   endtask

   task automatic quiet();
      in_valid   = 1'b0;
      in_src_vld = '0;
   endtask

   // Drive after a falling edge, then let combinational outputs settle.
   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      quiet();
      wb_valid = 1'b0;
      ex_empty = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();

      // ---------------- R1: reset state ----------------
      settle();
      chk("R1", "in_ready after reset", longint'(in_ready), 1);
      chk("R1", "ex_load after reset", longint'(ex_load), 0);
      chk("R1", "rf_rd_en after reset", longint'(rf_rd_en), 0);

      // ---------------- R2 sweep: bank = (reg + tid) % NB ----------------
      for (int t = 0; t < 8; t++) begin
         for (int r = 0; r < 16; r++) begin
            cyc(); offer(t, t*16 + r, 4'b0001, r, 0, 0, 0); ex_empty = 1'b1; settle();
            chk("R3", "in_ready with free unit", longint'(in_ready), 1);
            cyc(); quiet(); settle();
            chk("R2", "bank grant vector", longint'(rf_rd_en), longint'(1 << ((r + t) % NB)));
            chk("R4", "granted register", rd_reg((r + t) % NB), r);
            chk("R6", "no dispatch during grant", longint'(ex_load), 0);
            cyc(); settle();
            chk("R6", "dispatch after last grant", longint'(ex_load), 1);
            chk("R7", "ex_tag", longint'(ex_tag), longint'((t*16 + r) & 8'hFF));
            chk("R7", "ex_tid", longint'(ex_tid), t);
            chk("R3", "last-freed unit reused", longint'(ex_unit), NU - 1);
         end
      end

      // ---------------- R4: four reads to one bank, oldest first ----------------
      cyc(); offer(0, 8'hA5, 4'b1111, 0, 4, 8, 12); settle();
      cyc(); quiet(); settle();
      for (int k = 0; k < 4; k++) begin
         chk("R4", "single-bank grant vector", longint'(rf_rd_en), 1);
         chk("R4", "single-bank operand order", rd_reg(0), 4*k);
         chk("R6", "held while reads pending", longint'(ex_load), 0);
         cyc(); settle();
      end
      chk("R6", "dispatch after fourth grant", longint'(ex_load), 1);
      chk("R7", "tag after single-bank reads", longint'(ex_tag), 8'hA5);

      // R4: two banks in parallel; tid 1, regs 3,4,7,8 -> banks 0,1,0,1
      cyc(); offer(1, 8'h3C, 4'b1111, 3, 4, 7, 8); settle();
      cyc(); quiet(); settle();
      chk("R4", "parallel banks first grant", longint'(rf_rd_en), 3);
      chk("R4", "bank0 first", rd_reg(0), 3);
      chk("R4", "bank1 first", rd_reg(1), 4);
      cyc(); settle();
      chk("R4", "parallel banks second grant", longint'(rf_rd_en), 3);
      chk("R4", "bank0 second", rd_reg(0), 7);
      chk("R4", "bank1 second", rd_reg(1), 8);
      cyc(); settle();
      chk("R6", "dispatch after parallel reads", longint'(ex_load), 1);
      chk("R7", "tag after parallel reads", longint'(ex_tag), 8'h3C);

      // ---------------- R5: writeback claims bank ----------------
      cyc(); offer(0, 8'h55, 4'b0011, 1, 2, 0, 0); settle();
      cyc(); quiet(); wb_valid = 1'b1; wb_tid = 0; wb_reg = 5; settle();   // bank 1
      chk("R5", "only unblocked bank reads", longint'(rf_rd_en), 4);
      chk("R5", "unblocked bank register", rd_reg(2), 2);
      cyc(); wb_tid = 3; wb_reg = 2; settle();                          // bank 1 again
      chk("R5", "blocked bank still held", longint'(rf_rd_en), 0);
      chk("R6", "no dispatch while read held", longint'(ex_load), 0);
      cyc(); wb_valid = 1'b0; settle();
      chk("R5", "held read granted after writeback", longint'(rf_rd_en), 2);
      chk("R5", "held read register", rd_reg(1), 1);
      cyc(); settle();
      chk("R6", "dispatch after held read", longint'(ex_load), 1);

      // ---------------- R3/R7/R8/R9: fill, stall, round-robin ----------------
      do_reset();
      for (int i = 0; i < NU; i++) begin
         cyc(); offer(i, 8'h10 + i, 4'b0000, 0, 0, 0, 0); ex_empty = 1'b0; settle();
         chk("R3", "accepts while units free", longint'(in_ready), 1);
      end
      cyc(); offer(9, 8'h20, 4'b0000, 0, 0, 0, 0); settle();
      chk("R3", "stall when all units busy", longint'(in_ready), 0);
      chk("R7", "no dispatch while execute full", longint'(ex_load), 0);
      cyc(); settle();
      chk("R7", "still no dispatch while execute full", longint'(ex_load), 0);
      cyc(); ex_empty = 1'b1; settle();
      chk("R9", "ready through same-cycle release", longint'(in_ready), 1);
      chk("R8", "first dispatch is unit 0", longint'(ex_unit), 0);
      chk("R3", "unit 0 was allocated last", longint'(ex_tag), 8'h13);
      chk("R7", "dispatch fires", longint'(ex_load), 1);
      cyc(); quiet(); settle();
      chk("R8", "second dispatch unit 1", longint'(ex_unit), 1);
      chk("R3", "unit 1 tag", longint'(ex_tag), 8'h12);
      cyc(); settle();
      chk("R8", "third dispatch unit 2", longint'(ex_unit), 2);
      chk("R3", "unit 2 tag", longint'(ex_tag), 8'h11);
      cyc(); settle();
      chk("R8", "fourth dispatch unit 3", longint'(ex_unit), 3);
      chk("R3", "unit 3 tag", longint'(ex_tag), 8'h10);
      cyc(); settle();
      chk("R8", "wrap back to unit 0", longint'(ex_unit), 0);
      chk("R9", "refilled unit carries new tag", longint'(ex_tag), 8'h20);
      chk("R9", "refilled unit tid", longint'(ex_tid), 9);
      cyc(); settle();
      chk("R7", "idle after all dispatched", longint'(ex_load), 0);

      // ---------------- R10: fill one bank to full depth ----------------
      do_reset();
      cyc(); ex_empty = 1'b0; wb_valid = 1'b1; wb_tid = 0; wb_reg = 0;
      for (int k = 0; k < NU; k++) begin
         if (k != 0) cyc();
         offer(0, 8'h30 + k, 4'b1111, 16*k, 16*k + 4, 16*k + 8, 16*k + 12); settle();
         chk("R10", "accept while filling bank 0", longint'(in_ready), 1);
         chk("R5", "bank 0 held by writeback", longint'(rf_rd_en), 0);
      end
      cyc(); quiet(); settle();
      chk("R3", "pool full", longint'(in_ready), 0);
      cyc(); wb_valid = 1'b0; settle();
      for (int j = 0; j < 4*NU; j++) begin
         chk("R10", "full-queue grant vector", longint'(rf_rd_en), 1);
         chk("R10", "full-queue arrival order", rd_reg(0), 4*j);
         cyc(); settle();
      end
      chk("R10", "queue drained", longint'(rf_rd_en), 0);
      ex_empty = 1'b1; settle();
      for (int u = 0; u < NU; u++) begin
         chk("R8", "drain dispatch unit", longint'(ex_unit), u);
         chk("R3", "drain dispatch tag", longint'(ex_tag), 8'h30 + (NU - 1 - u));
         chk("R7", "drain dispatch fires", longint'(ex_load), 1);
         cyc(); settle();
      end
      chk("R7", "nothing left to dispatch", longint'(ex_load), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule